// File: doc/BRIEF.md
# Power Controller Configuration Register Bank

This block is the software-visible register bank of a power controller. Software reaches it over a simple word-addressed write/read port. Three kinds of settings live here: a wakeup interrupt, a control word, and two enable masks. The control word selects the clock and power-domain behaviour for the next low-power period and carries a low-power hint bit. The masks decide which raw wake requests and raw reset requests are allowed through. The bank drives the current control word and masks to the sequencing logic, and it raises the wakeup interrupt line.

The sequencer reports back to the bank with single-cycle strobes. One strobe marks the start of low-power entry, one marks the return to the active state, and one marks a registered reset request. On these strobes the bank locks and unlocks the control word and clears the hint bit on its own. The wakeup-enable and reset-enable masks each have a lock of their own. Software can close these locks but cannot reopen them. Read-only views show the masked wake and reset requests and a set of sticky fault flags.

Reads are combinational from the address. Writes take effect at the rising clock edge on which the write strobe is high. Reset is synchronous and active high.

Top module: `pmc_regbank`

## Requirements
- R1: After reset, all registers read their reset values. Interrupt state, interrupt enable, both masks and the fault flags read 0. The control lock and both mask locks read 1. The control word reads 0x180.
- R2: The interrupt state is bit 0 at offset 0x00. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. Writing 1 to bit 0 of offset 0x08 sets it. A return-to-active strobe also sets it. When a set and a clear fall in the same cycle, the set wins. Offset 0x08 reads 0.
- R3: The interrupt enable is bit 0 at offset 0x04. The interrupt output is high exactly when both the state bit and the enable bit are 1.
- R4: The control lock is bit 0 at offset 0x10 and software cannot write it. A low-power entry strobe clears it. A return-to-active strobe sets it. When both strobes fall in the same cycle, the lock is cleared.
- R5: The control word is at offset 0x14, and its writable bits are 8, 7, 6, 5, 4 and 0 (mask 0x1F1). Bit 8 is main domain power-up, bit 7 is USB clock in active state, bit 6 is USB clock in low power, bit 5 is IO clock in low power, bit 4 is core clock in low power, and bit 0 is the low-power hint. All other bits read 0. Writes are ignored while the control lock is 0. The word is also driven on cfg_control.
- R6: A low-power entry strobe or a reset-valid strobe clears the hint bit. If such a strobe falls in the same cycle as a software write to the control word, the hint bit is still cleared, while the other written bits still take effect.
- R7: The wakeup-mask lock is bit 0 at offset 0x1C. Writing 0 clears it, writing 1 has no effect, and once cleared it stays 0 until reset. The 6-bit wakeup mask is at offset 0x20, and writes to it are ignored while its lock is 0.
- R8: The reset-mask lock is bit 0 at offset 0x28 and behaves like the wakeup-mask lock. The 2-bit reset mask is at offset 0x2C, and writes to it are ignored while its lock is 0.
- R9: Offset 0x24 reads the raw wake requests ANDed with the wakeup mask. Offset 0x30 reads the raw reset requests ANDed with the reset mask. Both reads reflect the inputs in the same cycle.
- R10: Offset 0x40 holds the fault flags: bit 2 is a main-domain glitch, bit 1 is an escalation timeout, and bit 0 is a register integrity error. A flag is set by a high level on its fault input and is cleared only by reset.
- R11: Writes to read-only offsets (0x10, 0x24, 0x30, 0x40) and to unmapped offsets change no state. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ev_lp_entry | input | 1 | Low-power entry has started |
| ev_active_return | input | 1 | Device is back in the active state |
| ev_reset_valid | input | 1 | A valid reset request has been registered |
| raw_wake | input | 6 | Raw wake requests |
| raw_reset | input | 2 | Raw reset requests |
| fault_in | input | 3 | Fault indications to be captured |
| irq_wakeup | output | 1 | Wakeup interrupt |
| cfg_control | output | 9 | Current control word, bits 8:0 |
| cfg_wake_mask | output | 6 | Current wakeup mask |
| cfg_reset_mask | output | 2 | Current reset mask |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a software write to the control word meets a hardware strobe that clears the hint. The bench provokes this by raising the reset-valid strobe in the very cycle that a hint-setting write is issued. It then expects the written clock bits with the hint bit at 0. In the second, a write-1-to-clear of the interrupt state meets a return-to-active set. The bench drives both in one cycle and expects the state to read 1. It also drives the entry and return strobes together and expects the control lock to end up closed.

// File: rtl/pmc_regbank_pkg.sv
package pmc_regbank_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 32;
    localparam int WAKE_N  = 6;
    localparam int RREQ_N  = 2;
    localparam int FAULT_N = 3;
    localparam int CTRL_W  = 9;

    localparam logic [ADDR_W-1:0] OFS_IRQ_STATE  = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_IRQ_ENABLE = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_IRQ_FORCE  = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL_LOCK  = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL       = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_WAKE_LOCK  = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_WAKE_MASK  = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_WAKE_STAT  = 7'h24;
    localparam logic [ADDR_W-1:0] OFS_RREQ_LOCK  = 7'h28;
    localparam logic [ADDR_W-1:0] OFS_RREQ_MASK  = 7'h2C;
    localparam logic [ADDR_W-1:0] OFS_RREQ_STAT  = 7'h30;
    localparam logic [ADDR_W-1:0] OFS_FAULT      = 7'h40;

    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0000_01F1;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h180;

    typedef struct packed {
        logic       main_pwr_up;
        logic       usb_clk_active;
        logic       usb_clk_sleep;
        logic       io_clk_sleep;
        logic       core_clk_sleep;
        logic [2:0] unused_zero;
        logic       sleep_hint;
    } ctrl_word_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_wr_t;

    function automatic logic wr_hit(bus_wr_t b, logic [ADDR_W-1:0] ofs);
        return b.we && (b.addr == ofs);
    endfunction

    function automatic logic [DATA_W-1:0] zext_field(logic [DATA_W-1:0] v, int width);
        logic [DATA_W-1:0] m;
        m = (DATA_W'(1) << width) - DATA_W'(1);
        return v & m;
    endfunction

endpackage

// File: rtl/pmc_irq_unit.sv
module pmc_irq_unit (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic wr_state,
    input  logic wr_enable,
    input  logic wr_force,
    input  logic wbit,
    output logic state_q,
    output logic enable_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= 1'b0;
            enable_q <= 1'b0;
        end else begin
            if (wr_enable) enable_q <= wbit;
            state_q <= hw_set | (wr_force & wbit) | (state_q & ~(wr_state & wbit));
        end
    end

    assign irq = state_q & enable_q;
endmodule

// File: rtl/pmc_ctrl_unit.sv
module pmc_ctrl_unit
    import pmc_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_entry,
    input  logic              active_return,
    input  logic              reset_valid,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wr_val,
    output logic              lock_q,
    output ctrl_word_t        ctrl_q
);
    ctrl_word_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl && lock_q) ctrl_d = ctrl_word_t'(wr_val);
        ctrl_d.unused_zero = '0;
        if (lp_entry || reset_valid) ctrl_d.sleep_hint = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b1;
            ctrl_q <= ctrl_word_t'(CTRL_RESET);
        end else begin
            if (lp_entry)           lock_q <= 1'b0;
            else if (active_return) lock_q <= 1'b1;
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/pmc_lock_mask.sv
module pmc_lock_mask #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lock_wr,
    input  logic         lock_bit,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_val,
    input  logic [W-1:0] raw,
    output logic         open_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b1;
            mask_q <= '0;
        end else begin
            if (lock_wr && !lock_bit) open_q <= 1'b0;
            if (mask_wr && open_q)    mask_q <= mask_val;
        end
    end

    assign status = raw & mask_q;
endmodule

// File: rtl/pmc_regbank.sv
module pmc_regbank
    import pmc_regbank_pkg::*;
#(
    parameter int N_WAKE  = WAKE_N,
    parameter int N_RREQ  = RREQ_N,
    parameter int N_FAULT = FAULT_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_lp_entry,
    input  logic              ev_active_return,
    input  logic              ev_reset_valid,
    input  logic [N_WAKE-1:0] raw_wake,
    input  logic [N_RREQ-1:0] raw_reset,
    input  logic [N_FAULT-1:0] fault_in,
    output logic              irq_wakeup,
    output logic [CTRL_W-1:0] cfg_control,
    output logic [N_WAKE-1:0] cfg_wake_mask,
    output logic [N_RREQ-1:0] cfg_reset_mask
);
    bus_wr_t             wr;
    logic                intr_state, intr_enable;
    logic                ctrl_lock, wake_lock, reset_lock;
    ctrl_word_t          ctrl_q;
    logic [N_WAKE-1:0]   wake_stat;
    logic [N_RREQ-1:0]   rreq_stat;
    logic [N_FAULT-1:0]  fault_q;
    logic [DATA_W-1:0]   wd_ctrl, wd_wake, wd_rreq;

    assign wr      = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign wd_ctrl = wr.wdata & CTRL_WMASK;
    assign wd_wake = zext_field(wr.wdata, N_WAKE);
    assign wd_rreq = zext_field(wr.wdata, N_RREQ);

    pmc_irq_unit u_irq (
        .clk       (clk),
        .rst       (rst),
        .hw_set    (ev_active_return),
        .wr_state  (wr_hit(wr, OFS_IRQ_STATE)),
        .wr_enable (wr_hit(wr, OFS_IRQ_ENABLE)),
        .wr_force  (wr_hit(wr, OFS_IRQ_FORCE)),
        .wbit      (wr.wdata[0]),
        .state_q   (intr_state),
        .enable_q  (intr_enable),
        .irq       (irq_wakeup)
    );

    pmc_ctrl_unit u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .lp_entry      (ev_lp_entry),
        .active_return (ev_active_return),
        .reset_valid   (ev_reset_valid),
        .wr_ctrl       (wr_hit(wr, OFS_CTRL)),
        .wr_val        (wd_ctrl[CTRL_W-1:0]),
        .lock_q        (ctrl_lock),
        .ctrl_q        (ctrl_q)
    );

    pmc_lock_mask #(.W(N_WAKE)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .lock_wr  (wr_hit(wr, OFS_WAKE_LOCK)),
        .lock_bit (wr.wdata[0]),
        .mask_wr  (wr_hit(wr, OFS_WAKE_MASK)),
        .mask_val (wd_wake[N_WAKE-1:0]),
        .raw      (raw_wake),
        .open_q   (wake_lock),
        .mask_q   (cfg_wake_mask),
        .status   (wake_stat)
    );

    pmc_lock_mask #(.W(N_RREQ)) u_rreq (
        .clk      (clk),
        .rst      (rst),
        .lock_wr  (wr_hit(wr, OFS_RREQ_LOCK)),
        .lock_bit (wr.wdata[0]),
        .mask_wr  (wr_hit(wr, OFS_RREQ_MASK)),
        .mask_val (wd_rreq[N_RREQ-1:0]),
        .raw      (raw_reset),
        .open_q   (reset_lock),
        .mask_q   (cfg_reset_mask),
        .status   (rreq_stat)
    );

    for (genvar i = 0; i < N_FAULT; i++) begin : g_fault
        always_ff @(posedge clk) begin
            if (rst)              fault_q[i] <= 1'b0;
            else if (fault_in[i]) fault_q[i] <= 1'b1;
        end
    end

    assign cfg_control = ctrl_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_IRQ_STATE:  bus_rdata[0] = intr_state;
            OFS_IRQ_ENABLE: bus_rdata[0] = intr_enable;
            OFS_CTRL_LOCK:  bus_rdata[0] = ctrl_lock;
            OFS_CTRL:       bus_rdata[CTRL_W-1:0] = ctrl_q;
            OFS_WAKE_LOCK:  bus_rdata[0] = wake_lock;
            OFS_WAKE_MASK:  bus_rdata[N_WAKE-1:0] = cfg_wake_mask;
            OFS_WAKE_STAT:  bus_rdata[N_WAKE-1:0] = wake_stat;
            OFS_RREQ_LOCK:  bus_rdata[0] = reset_lock;
            OFS_RREQ_MASK:  bus_rdata[N_RREQ-1:0] = cfg_reset_mask;
            OFS_RREQ_STAT:  bus_rdata[N_RREQ-1:0] = rreq_stat;
            OFS_FAULT:      bus_rdata[N_FAULT-1:0] = fault_q;
            default:        bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmc_regbank_checker.sv
module pmc_regbank_checker #(
    parameter int N_WAKE  = 6,
    parameter int N_RREQ  = 2,
    parameter int N_FAULT = 3,
    parameter int CW      = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               ev_lp_entry,
    input logic               ev_active_return,
    input logic               ev_reset_valid,
    input logic               irq_wakeup,
    input logic [CW-1:0]      cfg_control,
    input logic [N_WAKE-1:0]  cfg_wake_mask,
    input logic [N_RREQ-1:0]  cfg_reset_mask,
    input logic               intr_state,
    input logic               intr_enable,
    input logic               ctrl_lock,
    input logic               wake_lock,
    input logic               reset_lock,
    input logic [N_FAULT-1:0] fault_q
);
    p_irq_set_r2: assert property (@(posedge clk) disable iff (rst)
        ev_active_return |=> intr_state);

    p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !intr_enable |-> !irq_wakeup);

    p_lock_close_r4: assert property (@(posedge clk) disable iff (rst)
        ev_lp_entry |=> !ctrl_lock);

    p_lock_open_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_active_return && !ev_lp_entry) |=> ctrl_lock);

    p_ctrl_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_lock && !ev_lp_entry && !ev_reset_valid) |=> $stable(cfg_control));

    p_hint_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_lp_entry || ev_reset_valid) |=> !cfg_control[0]);

    p_wake_lock_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !wake_lock |=> !wake_lock);

    p_wake_mask_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !wake_lock |=> $stable(cfg_wake_mask));

    p_rreq_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !reset_lock |=> !reset_lock);

    p_rreq_mask_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !reset_lock |=> $stable(cfg_reset_mask));

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (|fault_q) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
endmodule

bind pmc_regbank pmc_regbank_checker #(
    .N_WAKE (N_WAKE),
    .N_RREQ (N_RREQ),
    .N_FAULT(N_FAULT),
    .CW     (pmc_regbank_pkg::CTRL_W)
) u_checker (
    .clk              (clk),
    .rst              (rst),
    .ev_lp_entry      (ev_lp_entry),
    .ev_active_return (ev_active_return),
    .ev_reset_valid   (ev_reset_valid),
    .irq_wakeup       (irq_wakeup),
    .cfg_control      (cfg_control),
    .cfg_wake_mask    (cfg_wake_mask),
    .cfg_reset_mask   (cfg_reset_mask),
    .intr_state       (intr_state),
    .intr_enable      (intr_enable),
    .ctrl_lock        (ctrl_lock),
    .wake_lock        (wake_lock),
    .reset_lock       (reset_lock),
    .fault_q          (fault_q)
);

// File: tb/pmc_regbank_bench.sv
module pmc_regbank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_lp_entry = 1'b0;
    logic        ev_active_return = 1'b0;
    logic        ev_reset_valid = 1'b0;
    logic [5:0]  raw_wake = '0;
    logic [1:0]  raw_reset = '0;
    logic [2:0]  fault_in = '0;
    logic        irq_wakeup;
    logic [8:0]  cfg_control;
    logic [5:0]  cfg_wake_mask;
    logic [1:0]  cfg_reset_mask;

    int total = 0;
    int bad = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_regbank u_pmc_regbank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_lp_entry(ev_lp_entry), .ev_active_return(ev_active_return),
        .ev_reset_valid(ev_reset_valid), .raw_wake(raw_wake),
        .raw_reset(raw_reset), .fault_in(fault_in), .irq_wakeup(irq_wakeup),
        .cfg_control(cfg_control), .cfg_wake_mask(cfg_wake_mask),
        .cfg_reset_mask(cfg_reset_mask)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic step(logic we, logic [6:0] a, logic [31:0] d,
                        logic lp, logic act, logic rv);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        ev_lp_entry = lp; ev_active_return = act; ev_reset_valid = rv;
        @(negedge clk);
        bus_we = 1'b0; ev_lp_entry = 1'b0; ev_active_return = 1'b0; ev_reset_valid = 1'b0;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd_chk(string req, logic [6:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    function automatic logic [8:0] ctrl_map(int v);
        return {v[5], v[4], v[3], v[2], v[1], 3'b000, v[0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [8:0] cexp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_chk("R1", 7'h00, 32'h0);
        rd_chk("R1", 7'h04, 32'h0);
        rd_chk("R1", 7'h10, 32'h1);
        rd_chk("R1", 7'h14, 32'h180);
        rd_chk("R1", 7'h1C, 32'h1);
        rd_chk("R1", 7'h20, 32'h0);
        rd_chk("R1", 7'h28, 32'h1);
        rd_chk("R1", 7'h2C, 32'h0);
        rd_chk("R1", 7'h40, 32'h0);
        check("R1", {31'h0, irq_wakeup}, 32'h0);

        // R5 sweep of writable control bits, reserved bits forced high in the write
        for (int v = 0; v < 64; v++) begin
            wr(7'h14, {23'h7FFFFF, ctrl_map(v)} | 32'hFFFF_FE0E);
            rd_chk("R5", 7'h14, {23'h0, ctrl_map(v)});
            check("R5", {23'h0, cfg_control}, {23'h0, ctrl_map(v)});
        end

        // R4 / R6 entry strobe closes the lock and clears the hint
        wr(7'h14, 32'h1F1);
        step(1'b0, 7'h00, 32'h0, 1'b1, 1'b0, 1'b0);
        rd_chk("R4", 7'h10, 32'h0);
        rd_chk("R6", 7'h14, 32'h1F0);
        wr(7'h14, 32'h0);
        rd_chk("R5", 7'h14, 32'h1F0);
        wr(7'h10, 32'hFFFF_FFFF);
        rd_chk("R4", 7'h10, 32'h0);
        step(1'b0, 7'h00, 32'h0, 1'b0, 1'b1, 1'b0);
        rd_chk("R4", 7'h10, 32'h1);
        rd_chk("R2", 7'h00, 32'h1);
        wr(7'h00, 32'h1);
        rd_chk("R2", 7'h00, 32'h0);
        step(1'b0, 7'h00, 32'h0, 1'b1, 1'b1, 1'b0);
        rd_chk("R4", 7'h10, 32'h0);
        step(1'b0, 7'h00, 32'h0, 1'b0, 1'b1, 1'b0);
        rd_chk("R4", 7'h10, 32'h1);

        // R6 write of hint colliding with reset-valid strobe
        step(1'b1, 7'h14, 32'h0F1, 1'b0, 1'b0, 1'b1);
        rd_chk("R6", 7'h14, 32'h0F0);
        wr(7'h14, 32'h0B1);
        rd_chk("R6", 7'h14, 32'h0B1);
        step(1'b0, 7'h00, 32'h0, 1'b0, 1'b0, 1'b1);
        rd_chk("R6", 7'h14, 32'h0B0);

        // R2 force, write-0, collision of clear and hardware set
        wr(7'h00, 32'h1);
        rd_chk("R2", 7'h00, 32'h0);
        wr(7'h08, 32'h1);
        rd_chk("R2", 7'h00, 32'h1);
        rd_chk("R2", 7'h08, 32'h0);
        wr(7'h00, 32'h0);
        rd_chk("R2", 7'h00, 32'h1);
        step(1'b1, 7'h00, 32'h1, 1'b0, 1'b1, 1'b0);
        rd_chk("R2", 7'h00, 32'h1);

        // R3 all state/enable combinations
        for (int s = 0; s < 2; s++) begin
            for (int e = 0; e < 2; e++) begin
                wr(7'h00, 32'h1);
                if (s == 1) wr(7'h08, 32'h1);
                wr(7'h04, 32'(e));
                #1;
                check("R3", {31'h0, irq_wakeup}, 32'(s & e));
                rd_chk("R3", 7'h04, 32'(e));
            end
        end

        // R9 / R7 wake mask sweep against every raw pattern
        for (int m = 0; m < 64; m++) begin
            wr(7'h20, 32'hFFFF_FFC0 | 32'(m));
            rd_chk("R7", 7'h20, 32'(m));
            check("R7", {26'h0, cfg_wake_mask}, 32'(m));
            for (int r = 0; r < 64; r++) begin
                raw_wake = 6'(r);
                rd_chk("R9", 7'h24, 32'(m & r));
            end
        end
        raw_wake = '0;

        // R9 / R8 reset mask sweep
        for (int m = 0; m < 4; m++) begin
            wr(7'h2C, 32'hFFFF_FFFC | 32'(m));
            rd_chk("R8", 7'h2C, 32'(m));
            check("R8", {30'h0, cfg_reset_mask}, 32'(m));
            for (int r = 0; r < 4; r++) begin
                raw_reset = 2'(r);
                rd_chk("R9", 7'h30, 32'(m & r));
            end
        end
        raw_reset = '0;

        // R10 sticky faults
        @(negedge clk); fault_in = 3'b010;
        @(negedge clk); fault_in = 3'b000;
        rd_chk("R10", 7'h40, 32'h2);
        @(negedge clk); fault_in = 3'b001;
        @(negedge clk); fault_in = 3'b000;
        rd_chk("R10", 7'h40, 32'h3);
        @(negedge clk); fault_in = 3'b100;
        @(negedge clk); fault_in = 3'b000;
        repeat (3) @(negedge clk);
        rd_chk("R10", 7'h40, 32'h7);

        // R11 read-only and unmapped writes: current state is ctrl 0x0B0,
        // wake mask 0x3F, reset mask 0x3, irq state 1, enable 1
        cexp = 9'h0B0;
        wr(7'h24, 32'hFFFF_FFFF);
        wr(7'h30, 32'hFFFF_FFFF);
        wr(7'h40, 32'h0);
        wr(7'h0C, 32'hFFFF_FFFF);
        wr(7'h18, 32'hFFFF_FFFF);
        wr(7'h3C, 32'hFFFF_FFFF);
        wr(7'h44, 32'hFFFF_FFFF);
        rd_chk("R11", 7'h14, {23'h0, cexp});
        rd_chk("R11", 7'h20, 32'h3F);
        rd_chk("R11", 7'h2C, 32'h3);
        rd_chk("R11", 7'h00, 32'h1);
        rd_chk("R11", 7'h04, 32'h1);
        rd_chk("R11", 7'h40, 32'h7);
        rd_chk("R11", 7'h0C, 32'h0);
        rd_chk("R11", 7'h18, 32'h0);
        rd_chk("R11", 7'h3C, 32'h0);
        rd_chk("R11", 7'h44, 32'h0);

        // R7 wake lock
        wr(7'h1C, 32'h1);
        rd_chk("R7", 7'h1C, 32'h1);
        wr(7'h1C, 32'hFFFF_FFFE);
        rd_chk("R7", 7'h1C, 32'h0);
        wr(7'h20, 32'h15);
        rd_chk("R7", 7'h20, 32'h3F);
        wr(7'h1C, 32'h1);
        rd_chk("R7", 7'h1C, 32'h0);

        // R8 reset lock
        wr(7'h28, 32'h1);
        rd_chk("R8", 7'h28, 32'h1);
        wr(7'h28, 32'h0);
        rd_chk("R8", 7'h28, 32'h0);
        wr(7'h2C, 32'h1);
        rd_chk("R8", 7'h2C, 32'h3);
        wr(7'h28, 32'h1);
        rd_chk("R8", 7'h28, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule